// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide flash device. Bus writes reach it as single-cycle strobes, each with a 19-bit address and a data byte. It only recognises a command after a fixed address/data unlock pair. For erase it also demands a second unlock pair before the confirm byte. When a sequence completes, it raises a one-cycle start pulse for the program/erase controller that sits beside it. Any wrong step sends it back to plain array reads.

It also steers the read path. Normally reads return the data from the external array read port. After the signature command, reads return a maker code, a device code or the protection flag of one block, until the next write. While the controller reports busy, the decoder only passes on the commands marked as allowed on a separate input, and ignores every other write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) all start pulses are low, `sig_mode` is 0 and `rd_data` equals `arr_data`.
- R2: An unlock pair is data AAh at an address whose bits [14:0] equal 5555h, followed by data 55h at an address whose bits [14:0] equal 2AAAh. Address bits [18:15] are ignored for these cycles and for the command cycles that compare against 5555h.
- R3: Unlock, then A0h at 5555h, then any fourth write: `go_prog` pulses in the cycle after that fourth strobe, and `tgt_addr`/`tgt_data` hold that write's address and data.
- R4: Unlock, 80h at 5555h, unlock, then 10h at 5555h pulses `go_chip_erase` in the cycle after the sixth strobe.
- R5: The same prefix ending in 30h at any address pulses `go_blk_erase`, and `tgt_addr` holds that address.
- R6: A wrong unlock data byte or address, or a sixth byte that is neither 10h at 5555h nor 30h, ends the sequence with no pulse. The decoder returns to idle, so a later command byte needs a fresh unlock.
- R7: F0h written from idle at any address, or F0h at 5555h after an unlock pair, pulses `go_reset`.
- R8: B0h from idle at any address pulses `go_suspend`, and 30h from idle at any address pulses `go_resume`. Neither needs unlock cycles.
- R9: Unlock then 90h at 5555h pulses `go_sig` and sets `sig_mode`. In signature mode a read with A1=0 and A6=0 returns 20h (A0=0) or E2h (A0=1). A read with A1=1 and A0=0 returns 01h if `prot_map[rd_addr[18:16]]` is 1, else 00h. Any other signature read returns 00h.
- R10: Signature mode ends at the next write strobe of any kind. `rd_data` then follows `arr_data` again.
- R11: While `busy` is 1, a write cannot start a sequence or a multi-cycle command. It only gives F0h→`go_reset` if `busy_ok[0]`, B0h→`go_suspend` if `busy_ok[1]`, and 30h→`go_resume` if `busy_ok[2]`. The decoder is left in idle.
- R12: Each accepted command gives exactly one start pulse, one cycle wide, and at most one pulse is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Program/erase controller is busy |
| busy_ok | input | 3 | Commands allowed while busy: [0] reset, [1] suspend, [2] resume |
| rd_addr | input | 19 | Read address |
| arr_data | input | 8 | Array data for `rd_addr` from the external read port |
| prot_map | input | 8 | Per-block protection flags |
| rd_data | output | 8 | Read data |
| sig_mode | output | 1 | Signature read mode active |
| go_prog | output | 1 | Program start pulse |
| go_chip_erase | output | 1 | Chip erase start pulse |
| go_blk_erase | output | 1 | Block erase start pulse |
| go_sig | output | 1 | Signature mode entry pulse |
| go_reset | output | 1 | Reset command pulse |
| go_suspend | output | 1 | Erase suspend pulse |
| go_resume | output | 1 | Erase resume pulse |
| tgt_addr | output | 19 | Address latched with program or block erase |
| tgt_data | output | 8 | Data latched with program |

## Verification
The assertions check the local cycle-to-cycle facts on every cycle:
- pulses stay one-hot and each follows a strobe;
- reset, suspend and chip-erase pulses follow the right byte;
- no multi-cycle command starts out of a busy write;
- the target latch matches the accepting write;
- signature mode drops after a write;
- the read mux returns array data or protection flags as selected.

Whether a whole six-cycle sequence is honoured or aborted depends on the history of earlier writes. That includes an abort on a wrong address in the middle, and the fact that writes made while busy leave no partial unlock. Only the bench's ordered write scenarios can show these.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    localparam int DATA_W = 8;
    localparam int KEY_W  = 15;

    localparam logic [KEY_W-1:0]  KEY_ADR_P = 15'h5555;
    localparam logic [KEY_W-1:0]  KEY_ADR_Q = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_BYTE_B  = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROGRAM  = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ERASE    = 8'h80;
    localparam logic [DATA_W-1:0] OP_IDENT    = 8'h90;
    localparam logic [DATA_W-1:0] OP_RESET    = 8'hF0;
    localparam logic [DATA_W-1:0] OP_SUSPEND  = 8'hB0;
    localparam logic [DATA_W-1:0] OP_THIRTY   = 8'h30;
    localparam logic [DATA_W-1:0] OP_CHIP     = 8'h10;

    localparam logic [DATA_W-1:0] ID_MAKER  = 8'h20;
    localparam logic [DATA_W-1:0] ID_DEVICE = 8'hE2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM,
        SQ_ESET,
        SQ_EKEY1,
        SQ_EKEY2
    } seq_t;

    typedef struct packed {
        logic at_p;
        logic at_q;
        logic d_ka;
        logic d_kb;
        logic d_prog;
        logic d_erase;
        logic d_ident;
        logic d_rst;
        logic d_susp;
        logic d_thirty;
        logic d_chip;
    } wr_class_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic blk;
        logic sig;
        logic rst;
        logic susp;
        logic res;
    } go_t;

    function automatic logic key_hit(input logic [KEY_W-1:0] a,
                                     input logic [KEY_W-1:0] k);
        return a == k;
    endfunction

endpackage

// File: rtl/fcu_classify.sv
module fcu_classify
    import fcu_pkg::*;
(
    input  logic [KEY_W-1:0]  key_addr,
    input  logic [DATA_W-1:0] data,
    output wr_class_t         cls
);
    always_comb begin
        cls.at_p     = key_hit(key_addr, KEY_ADR_P);
        cls.at_q     = key_hit(key_addr, KEY_ADR_Q);
        cls.d_ka     = data == KEY_BYTE_A;
        cls.d_kb     = data == KEY_BYTE_B;
        cls.d_prog   = data == OP_PROGRAM;
        cls.d_erase  = data == OP_ERASE;
        cls.d_ident  = data == OP_IDENT;
        cls.d_rst    = data == OP_RESET;
        cls.d_susp   = data == OP_SUSPEND;
        cls.d_thirty = data == OP_THIRTY;
        cls.d_chip   = data == OP_CHIP;
    end
endmodule

// File: rtl/fcu_seq.sv
module fcu_seq
    import fcu_pkg::*;
#(
    parameter int ADDR_W = 19
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              busy,
    input  logic [2:0]        busy_ok,
    input  wr_class_t         cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output go_t               go,
    output logic              sig_mode,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data
);
    seq_t st, st_n;
    go_t  go_n;
    logic cap;

    always_comb begin
        st_n = st;
        go_n = '0;
        cap  = 1'b0;
        if (stb) begin
            if (busy) begin
                st_n      = SQ_IDLE;
                go_n.rst  = cls.d_rst    & busy_ok[0];
                go_n.susp = cls.d_susp   & busy_ok[1];
                go_n.res  = cls.d_thirty & busy_ok[2];
            end else begin
                unique case (st)
                    SQ_IDLE: begin
                        if (cls.d_rst)                go_n.rst  = 1'b1;
                        else if (cls.d_susp)          go_n.susp = 1'b1;
                        else if (cls.d_thirty)        go_n.res  = 1'b1;
                        else if (cls.d_ka && cls.at_p) st_n     = SQ_KEY1;
                    end
                    SQ_KEY1:  st_n = (cls.d_kb && cls.at_q) ? SQ_KEY2 : SQ_IDLE;
                    SQ_KEY2: begin
                        st_n = SQ_IDLE;
                        if (cls.at_p) begin
                            if (cls.d_prog)       st_n     = SQ_PGM;
                            else if (cls.d_erase) st_n     = SQ_ESET;
                            else if (cls.d_ident) go_n.sig = 1'b1;
                            else if (cls.d_rst)   go_n.rst = 1'b1;
                        end
                    end
                    SQ_PGM: begin
                        go_n.prog = 1'b1;
                        cap       = 1'b1;
                        st_n      = SQ_IDLE;
                    end
                    SQ_ESET:  st_n = (cls.d_ka && cls.at_p) ? SQ_EKEY1 : SQ_IDLE;
                    SQ_EKEY1: st_n = (cls.d_kb && cls.at_q) ? SQ_EKEY2 : SQ_IDLE;
                    SQ_EKEY2: begin
                        st_n = SQ_IDLE;
                        if (cls.d_chip && cls.at_p) begin
                            go_n.chip = 1'b1;
                        end else if (cls.d_thirty) begin
                            go_n.blk = 1'b1;
                            cap      = 1'b1;
                        end
                    end
                    default:  st_n = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            go       <= '0;
            sig_mode <= 1'b0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else begin
            st <= st_n;
            go <= go_n;
            if (go_n.sig)  sig_mode <= 1'b1;
            else if (stb)  sig_mode <= 1'b0;
            if (cap) begin
                tgt_addr <= addr;
                tgt_data <= data;
            end
        end
    end
endmodule

// File: rtl/fcu_rdmux.sv
module fcu_rdmux
    import fcu_pkg::*;
#(
    parameter int BLK_W = 3
)(
    input  logic                  sig_mode,
    input  logic [1:0]            sel_lo,
    input  logic                  sel_a6,
    input  logic [BLK_W-1:0]      blk,
    input  logic [DATA_W-1:0]     arr_data,
    input  logic [(1<<BLK_W)-1:0] prot_map,
    output logic [DATA_W-1:0]     rd_data
);
    always_comb begin
        rd_data = arr_data;
        if (sig_mode) begin
            unique case (sel_lo)
                2'b00:   rd_data = sel_a6 ? '0 : ID_MAKER;
                2'b01:   rd_data = sel_a6 ? '0 : ID_DEVICE;
                2'b10:   rd_data = {{(DATA_W-1){1'b0}}, prot_map[blk]};
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcu_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 3,
    localparam int NUM_BLK = 1 << BLK_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [2:0]        busy_ok,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [NUM_BLK-1:0] prot_map,
    output logic [DATA_W-1:0] rd_data,
    output logic              sig_mode,
    output logic              go_prog,
    output logic              go_chip_erase,
    output logic              go_blk_erase,
    output logic              go_sig,
    output logic              go_reset,
    output logic              go_suspend,
    output logic              go_resume,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data
);
    wr_class_t cls;
    go_t       go;

    fcu_classify u_cls (
        .key_addr (wr_addr[KEY_W-1:0]),
        .data     (wr_data),
        .cls      (cls)
    );

    fcu_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb      (wr_stb),
        .busy     (busy),
        .busy_ok  (busy_ok),
        .cls      (cls),
        .addr     (wr_addr),
        .data     (wr_data),
        .go       (go),
        .sig_mode (sig_mode),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data)
    );

    fcu_rdmux #(.BLK_W(BLK_W)) u_rd (
        .sig_mode (sig_mode),
        .sel_lo   (rd_addr[1:0]),
        .sel_a6   (rd_addr[6]),
        .blk      (rd_addr[ADDR_W-1 -: BLK_W]),
        .arr_data (arr_data),
        .prot_map (prot_map),
        .rd_data  (rd_data)
    );

    assign go_prog       = go.prog;
    assign go_chip_erase = go.chip;
    assign go_blk_erase  = go.blk;
    assign go_sig        = go.sig;
    assign go_reset      = go.rst;
    assign go_suspend    = go.susp;
    assign go_resume     = go.res;
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 3
)(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_stb,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [7:0]            wr_data,
    input logic                  busy,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [7:0]            arr_data,
    input logic [(1<<BLK_W)-1:0] prot_map,
    input logic [7:0]            rd_data,
    input logic                  sig_mode,
    input logic                  go_prog,
    input logic                  go_chip_erase,
    input logic                  go_blk_erase,
    input logic                  go_sig,
    input logic                  go_reset,
    input logic                  go_suspend,
    input logic                  go_resume,
    input logic [ADDR_W-1:0]     tgt_addr,
    input logic [7:0]            tgt_data
);
    logic [6:0] pv;
    assign pv = {go_prog, go_chip_erase, go_blk_erase, go_sig,
                 go_reset, go_suspend, go_resume};

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (pv == '0 && !sig_mode));                            // R1
    AST_ARRAY_READ: assert property (@(posedge clk) disable iff (rst)
        !sig_mode |-> rd_data == arr_data);                                 // R1
    AST_PROG_TARGET: assert property (@(posedge clk) disable iff (rst)
        go_prog |-> (tgt_addr == $past(wr_addr) && tgt_data == $past(wr_data))); // R3
    AST_CHIP_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        go_chip_erase |-> ($past(wr_data) == 8'h10 && $past(wr_addr[14:0]) == 15'h5555)); // R4
    AST_BLK_TARGET: assert property (@(posedge clk) disable iff (rst)
        go_blk_erase |-> (tgt_addr == $past(wr_addr) && $past(wr_data) == 8'h30)); // R5
    AST_RESET_BYTE: assert property (@(posedge clk) disable iff (rst)
        go_reset |-> $past(wr_data) == 8'hF0);                              // R7
    AST_SUSPEND_BYTE: assert property (@(posedge clk) disable iff (rst)
        go_suspend |-> $past(wr_data) == 8'hB0);                            // R8
    AST_PROT_READ: assert property (@(posedge clk) disable iff (rst)
        (sig_mode && rd_addr[1:0] == 2'b10) |->
        (rd_data[7:1] == '0 && rd_data[0] == prot_map[rd_addr[ADDR_W-1 -: BLK_W]])); // R9
    AST_SIG_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_stb) && !go_sig) |-> !sig_mode);                          // R10
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (go_prog || go_chip_erase || go_blk_erase || go_sig) |-> !$past(busy)); // R11
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pv));                                                      // R12
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (pv != '0) |-> $past(wr_stb));                                      // R12
endmodule

bind flash_cmd_decoder fcu_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .busy          (busy),
    .rd_addr       (rd_addr),
    .arr_data      (arr_data),
    .prot_map      (prot_map),
    .rd_data       (rd_data),
    .sig_mode      (sig_mode),
    .go_prog       (go_prog),
    .go_chip_erase (go_chip_erase),
    .go_blk_erase  (go_blk_erase),
    .go_sig        (go_sig),
    .go_reset      (go_reset),
    .go_suspend    (go_suspend),
    .go_resume     (go_resume),
    .tgt_addr      (tgt_addr),
    .tgt_data      (tgt_data)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic [2:0]  busy_ok = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  arr_data = 8'h3C;
    logic [7:0]  prot_map = 8'b1010_0110;
    logic [7:0]  rd_data;
    logic        sig_mode;
    logic        go_prog, go_chip_erase, go_blk_erase, go_sig;
    logic        go_reset, go_suspend, go_resume;
    logic [18:0] tgt_addr;
    logic [7:0]  tgt_data;
    logic [6:0]  pv;
    logic [6:0]  got;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .busy_ok(busy_ok), .rd_addr(rd_addr), .arr_data(arr_data),
        .prot_map(prot_map), .rd_data(rd_data), .sig_mode(sig_mode),
        .go_prog(go_prog), .go_chip_erase(go_chip_erase), .go_blk_erase(go_blk_erase),
        .go_sig(go_sig), .go_reset(go_reset), .go_suspend(go_suspend),
        .go_resume(go_resume), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    // pulse vector order: prog, chip, blk, sig, reset, suspend, resume
    assign pv = {go_prog, go_chip_erase, go_blk_erase, go_sig, go_reset, go_suspend, go_resume};

    localparam int NV = 45;
    localparam logic [33:0] VEC [NV] = '{
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00}, {19'h05555, 8'hA0, 7'h00},
        {19'h12345, 8'h5A, 7'h40},                                   // R3 program
        {19'h7D555, 8'hAA, 7'h00}, {19'h7AAAA, 8'h55, 7'h00}, {19'h05555, 8'hA0, 7'h00},
        {19'h00010, 8'h00, 7'h40},                                   // R2 high bits ignored
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00}, {19'h05555, 8'h80, 7'h00},
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},
        {19'h05555, 8'h10, 7'h20},                                   // R4 chip erase
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00}, {19'h05555, 8'h80, 7'h00},
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},
        {19'h30000, 8'h30, 7'h10},                                   // R5 block erase
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h54, 7'h00},        // R6 bad key data
        {19'h05555, 8'hA0, 7'h00}, {19'h00000, 8'h00, 7'h00},
        {19'h05554, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},        // R6 bad key addr
        {19'h05555, 8'hA0, 7'h00}, {19'h00000, 8'h12, 7'h00},
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00}, {19'h05555, 8'h80, 7'h00},
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},
        {19'h05555, 8'h20, 7'h00}, {19'h05555, 8'h10, 7'h00},        // R6 bad confirm
        {19'h00000, 8'hF0, 7'h04},                                   // R7 bare reset
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},
        {19'h05555, 8'hF0, 7'h04},                                   // R7 unlocked reset
        {19'h41234, 8'hB0, 7'h02}, {19'h00000, 8'h30, 7'h01},        // R8
        {19'h05555, 8'hAA, 7'h00}, {19'h02AAA, 8'h55, 7'h00},
        {19'h05555, 8'h90, 7'h08},                                   // R9 signature entry
        {19'h00000, 8'h00, 7'h00}                                    // R10 write ends it
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        got = pv;
        wr_stb = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [18:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic unlock;
        do_wr(19'h05555, 8'hAA);
        do_wr(19'h02AAA, 8'h55);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pulses", {25'h0, pv}, 32'h0);
        check("R1 sig_mode", {31'h0, sig_mode}, 32'h0);
        rd_check("R1 array read", 19'h00001, 8'h3C);

        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i][33:15], VEC[i][14:7]);
            check($sformatf("R2-table row %0d", i), {25'h0, got}, {25'h0, VEC[i][6:0]});
        end
        check("R10 sig cleared", {31'h0, sig_mode}, 32'h0);

        // R3 target latch
        unlock();
        do_wr(19'h05555, 8'hA0);
        do_wr(19'h6ABCD, 8'hC3);
        check("R3 prog pulse", {25'h0, got}, 32'h40);
        check("R3 tgt_addr", {13'h0, tgt_addr}, 32'h6ABCD);
        check("R3 tgt_data", {24'h0, tgt_data}, 32'hC3);

        // R5 block target
        unlock();
        do_wr(19'h05555, 8'h80);
        unlock();
        do_wr(19'h51111, 8'h30);
        check("R5 blk pulse", {25'h0, got}, 32'h10);
        check("R5 tgt_addr", {13'h0, tgt_addr}, 32'h51111);

        // R12 pulse width
        do_wr(19'h00000, 8'hF0);
        check("R12 pulse high", {25'h0, got}, 32'h04);
        @(negedge clk);
        check("R12 pulse one cycle", {25'h0, pv}, 32'h0);

        // R9 signature reads
        unlock();
        do_wr(19'h05555, 8'h90);
        check("R9 sig_mode", {31'h0, sig_mode}, 32'h1);
        rd_check("R9 maker", 19'h00000, 8'h20);
        rd_check("R9 device", 19'h00001, 8'hE2);
        rd_check("R9 A6 high", 19'h00040, 8'h00);
        rd_check("R9 prot blk1", 19'h10002, 8'h01);
        rd_check("R9 prot blk0", 19'h00002, 8'h00);
        rd_check("R9 prot blk7", 19'h70002, 8'h01);
        rd_check("R9 A1A0 high", 19'h00003, 8'h00);
        do_wr(19'h00000, 8'h77);
        check("R10 any write ends", {31'h0, sig_mode}, 32'h0);
        rd_check("R10 array back", 19'h00000, 8'h3C);

        // R11 busy filtering
        busy = 1'b1; busy_ok = 3'b010;
        unlock();
        check("R11 unlock ignored", {25'h0, got}, 32'h0);
        do_wr(19'h05555, 8'hA0);
        do_wr(19'h00100, 8'h11);
        check("R11 no program", {25'h0, got}, 32'h0);
        do_wr(19'h00000, 8'hB0);
        check("R11 suspend allowed", {25'h0, got}, 32'h02);
        do_wr(19'h00000, 8'hF0);
        check("R11 reset masked", {25'h0, got}, 32'h0);
        do_wr(19'h00000, 8'h30);
        check("R11 resume masked", {25'h0, got}, 32'h0);
        busy_ok = 3'b101;
        do_wr(19'h00000, 8'hF0);
        check("R11 reset allowed", {25'h0, got}, 32'h04);
        do_wr(19'h00000, 8'h30);
        check("R11 resume allowed", {25'h0, got}, 32'h01);
        do_wr(19'h00000, 8'hB0);
        check("R11 suspend masked", {25'h0, got}, 32'h0);
        do_wr(19'h05555, 8'hAA);
        do_wr(19'h02AAA, 8'h55);
        busy = 1'b0;
        do_wr(19'h05555, 8'hA0);
        do_wr(19'h00200, 8'h22);
        check("R11 busy key left no progress", {25'h0, got}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule